// File: doc/BRIEF.md
# Self-Timed Parallel EEPROM Controller

This block holds the control logic and storage of an 8192-byte parallel EEPROM. A host bus drives three active-low strobes, `ce_n` (chip enable), `oe_n` (output enable) and `we_n` (write enable), together with a 13-bit address. The bidirectional data bus is split into `din` plus a `dout`/`dout_en` pair. All three strobes pass through a two-flop synchronizer before the block decodes them. A read is active while chip enable and output enable are both low. A byte write opens when chip enable and write enable are both low while output enable is high. The block accepts the write whether the chip-enable strobe or the write-enable strobe was the last to complete that condition.

A write does not reach the array at once. The address is captured when the write condition first appears, and the data is captured when the condition ends. An internal timer then runs for `WRITE_CYCLES` clocks, and the byte is committed only when the timer expires. While the timer runs, `ready` is low, so `ready` works as a ready/busy indicator. A read during that time returns the byte being written with its top bit inverted, so a host can poll the bus and detect completion when the top bit turns true. Write requests that arrive while the timer runs are dropped. Setting the `READY_PIN` parameter to 0 selects a variant in which `ready` is tied high and stays constant.

Top module: `eeprom_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `dout_en` is 0.
- R2: Once the synchronized `ce_n` and `oe_n` are both 0, `dout_en` is 1 and `dout` equals the stored byte at `addr`. This holds from the second clock after both inputs are low, because the strobes pass through a two-flop synchronizer.
- R3: `dout_en` is 0 whenever `ce_n` or `oe_n` is 1, including while a write is pending.
- R4: A write opens only when `ce_n`=0 and `we_n`=0 while `oe_n`=1. Holding all three strobes low writes nothing and leaves `ready` at 1.
- R5: Writes work whether `we_n` or `ce_n` is the last strobe to go low. The address is captured when the write condition starts, so an address change made afterwards does not redirect the write. The data is captured when the condition ends.
- R6: With `READY_PIN`=1, `ready` is 0 for exactly `WRITE_CYCLES` consecutive clocks after each accepted write.
- R7: The written byte enters the array only when the timer expires. A read made before then does not return the new byte as plain data.
- R8: While the timer runs, a read at any address returns the pending byte with bit 7 inverted and bits 6..0 unchanged. After the timer ends, a read returns the stored byte.
- R9: A write cycle that starts while the timer runs is ignored. Neither its address nor its data is stored.
- R10: With `READY_PIN`=0, `ready` stays 1 throughout, including during writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 13 | Byte address |
| din | input | 8 | Data bus input side |
| dout | output | 8 | Data bus output side |
| dout_en | output | 1 | Drive enable for the data bus |
| ready | output | 1 | 1 when idle, 0 while an internal write runs |

## Verification
Two writes exercise the byte-write path, one ending on `we_n` and one ending on `ce_n`. The first moves the address after the write opens, which shows whether the address is taken at the opening edge or later. Polling reads are made with pending bytes whose bit 7 is 1 and whose bit 7 is 0, and at a foreign address, so an inverted flag can be told apart from a stale array value. Further patterns cover a write attempted with output enable low and a second write issued while the timer runs; both must leave the array and the busy line untouched. Half-open strobe pairs check that the data bus stays undriven.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobes_t;

  // write condition: chip and write enables low, output enable high
  function automatic logic wr_condition(input strobes_t s);
    return !s.ce_n && !s.we_n && s.oe_n;
  endfunction

  // read condition: chip and output enables low
  function automatic logic rd_condition(input strobes_t s);
    return !s.ce_n && !s.oe_n;
  endfunction

  // value a host sees while the write is pending: top bit flipped
  function automatic logic [7:0] poll_byte(input logic [7:0] pending);
    return {~pending[7], pending[6:0]};
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/eeprom_cycle_dec.sv
module eeprom_cycle_dec
  import eeprom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  strobes_t strb,
  input  logic     busy,
  output logic     wr_start,
  output logic     wr_end,
  output logic     rd_active
);
  logic wr_now, wr_q, wr_open;

  assign wr_now    = wr_condition(strb);
  assign rd_active = rd_condition(strb);
  assign wr_start  = wr_now && !wr_q && !busy;
  assign wr_end    = wr_open && !wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wr_open <= 1'b0;
    end else begin
      wr_q <= wr_now;
      if (wr_start)    wr_open <= 1'b1;
      else if (wr_end) wr_open <= 1'b0;
    end
  end

  // R9: no write opens while the timer runs
  a_r9_no_open_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !wr_open || $past(wr_open));
endmodule

// File: rtl/eeprom_wtimer.sv
module eeprom_wtimer #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt - 1'b1;
    end
  end

  // R6: expiry always ends the busy interval
  a_r6_expiry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R6: a start never lands on a running timer
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 50000,
  parameter bit READY_PIN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ready
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [2:0] strb_raw, strb_sync;
  strobes_t   strb;
  logic wr_start, wr_end, rd_active, busy, commit;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] mem [DEPTH];

  assign strb_raw = {ce_n, oe_n, we_n};
  assign strb     = strobes_t'(strb_sync);

  strobe_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(strb_raw), .sync_out(strb_sync));

  eeprom_cycle_dec u_dec (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busy(busy),
    .wr_start(wr_start), .wr_end(wr_end), .rd_active(rd_active));

  eeprom_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_end), .busy(busy), .done(commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr <= '0;
      wdata <= '0;
    end else begin
      if (wr_start) waddr <= addr;
      if (wr_end)   wdata <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[waddr] <= wdata;
  end

  assign dout_en = rd_active;
  always_comb begin
    if (busy) dout = {~wdata[DATA_W-1], wdata[DATA_W-2:0]};
    else      dout = mem[addr];
  end

  if (READY_PIN) begin : g_ready
    assign ready = !busy;
  end else begin : g_no_ready
    assign ready = 1'b1;
  end

  // R3: the bus stays undriven after either enable has been high long enough
  a_r3_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n, 2) || $past(oe_n, 2)) && $past(ce_n) == $past(ce_n, 2)
      && $past(oe_n) == $past(oe_n, 2) |-> !dout_en);
  // R9: the pending address and data hold still for the whole write
  a_r9_pending_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(waddr) && $stable(wdata));
  // R8: a polling read shows the inverted top bit
  a_r8_poll_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dout_en |-> dout[DATA_W-1] != wdata[DATA_W-1]);
  // R7: the array write closes the busy interval
  a_r7_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: tb/eeprom_ctrl_test.sv
module eeprom_ctrl_test;
  localparam int WC = 40;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, dout_nr;
  logic        dout_en, dout_en_nr, ready, ready_nr;

  int checks = 0, errors = 0;
  int lowcnt = 0, last_len = 0, nr_low = 0;
  logic sample = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  eeprom_ctrl #(.WRITE_CYCLES(WC), .READY_PIN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready));

  eeprom_ctrl #(.WRITE_CYCLES(WC), .READY_PIN(1'b0)) uut_nr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout_nr), .dout_en(dout_en_nr), .ready(ready_nr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the driver raises sample
  always @(negedge clk) begin
    if (sample && exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dout_en == e[8], {t, " enable"}, dout_en, e[8]);
      if (e[8]) check(dout == e[7:0], {t, " data"}, dout, e[7:0]);
    end
    if (!ready) lowcnt++;
    else if (lowcnt != 0) begin last_len = lowcnt; lowcnt = 0; end
    if (rst_n && !ready_nr) nr_low++;
  end

  task automatic probe(input logic [12:0] a, input logic c, input logic o,
                       input logic [7:0] exp, input bit en, input string tag);
    @(negedge clk); addr = a; ce_n = c; oe_n = o; we_n = 1;
    repeat (4) @(negedge clk);
    exp_q.push_back({en, exp}); tag_q.push_back(tag);
    @(posedge clk); sample = 1;
    @(negedge clk); @(posedge clk); sample = 0;
    @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d,
                          input bit ce_last, input bit move_addr);
    @(negedge clk); addr = a; oe_n = 1; din = ~d;
    if (ce_last) begin we_n = 0; repeat (3) @(negedge clk); ce_n = 0; end
    else begin ce_n = 0; repeat (3) @(negedge clk); we_n = 0; end
    repeat (4) @(negedge clk);
    if (move_addr) addr = a ^ 13'h1;
    din = d;
    repeat (3) @(negedge clk);
    if (ce_last) ce_n = 1; else we_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1; we_n = 1; din = '0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1, "R1 ready after reset", ready, 1);
    check(dout_en == 0, "R1 bus idle after reset", dout_en, 0);

    // R5 we_n-ended write, then one that moves the address after opening
    do_write(13'h0004, 8'h11, 0, 0);
    wait_idle();
    check(last_len == WC, "R6 busy length", last_len, WC);
    do_write(13'h0005, 8'hA5, 0, 1);
    probe(13'h0005, 0, 0, 8'h25, 1, "R8 poll bit7=1");   // also R7
    wait_idle();
    check(last_len == WC, "R6 busy length second", last_len, WC);
    probe(13'h0005, 0, 0, 8'hA5, 1, "R2 R7 read committed");
    probe(13'h0004, 0, 0, 8'h11, 1, "R5 address held at open");

    // R5 ce_n-ended write
    do_write(13'h1FFF, 8'h3C, 1, 0);
    wait_idle();
    probe(13'h1FFF, 0, 0, 8'h3C, 1, "R5 ce-controlled write");

    // R3 half-open enables
    probe(13'h1FFF, 0, 1, 8'h00, 0, "R3 oe high");
    probe(13'h1FFF, 1, 0, 8'h00, 0, "R3 ce high");

    // R4 all strobes low: no write
    @(negedge clk); addr = 13'h1FFF; din = 8'h99; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (10) @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1;
    repeat (4) @(negedge clk);
    check(lowcnt == 0 && ready == 1, "R4 no busy", lowcnt, 0);
    probe(13'h1FFF, 0, 0, 8'h3C, 1, "R4 array unchanged");

    // R9 write during busy is dropped
    do_write(13'h0010, 8'h77, 0, 0);
    check(ready == 0, "R6 busy after write", ready, 0);
    do_write(13'h0004, 8'hEE, 0, 0);
    wait_idle();
    check(last_len == WC, "R9 single busy interval", last_len, WC);
    probe(13'h0004, 0, 0, 8'h11, 1, "R9 dropped write");
    probe(13'h0010, 0, 0, 8'h77, 1, "R9 first write kept");

    // R8 poll with bit7=0 at a foreign address
    do_write(13'h0020, 8'h5A, 1, 0);
    probe(13'h0004, 0, 0, 8'hDA, 1, "R8 poll bit7=0");
    check(dout_nr == 8'h00 || ready_nr == 1, "R10 ready pin tied", ready_nr, 1);
    wait_idle();
    probe(13'h0020, 0, 0, 8'h5A, 1, "R8 after completion");

    check(nr_low == 0, "R10 ready never low", nr_low, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule